// File: doc/BRIEF.md
# B3ZS line encoder

This block turns a unipolar serial bit stream into a three-level line signal carried on two rails, one for positive pulses and one for negative pulses. A bit is taken on each clock in which `in_valid` is high. A symbol leaves on the rails in the following clock, flagged by `out_valid`. Each one is sent as a mark whose polarity alternates. Each group of three zeros is rewritten as a pattern that contains a deliberate polarity violation. This keeps long pulse-free stretches off the line, so a downstream clock recovery circuit always sees transitions.

The bits pass through a three-stage lookahead window. A zero run is therefore recognised in full before its first bit is encoded. A sequencer state machine walks through each substitution. Its states are `SQ_FILL` (window still loading), `SQ_NORM` (plain encoding), `SQ_HOLD` (middle zero of a substitution) and `SQ_VIOL` (violation pulse due). The transitions are:
- `SQ_FILL` to `SQ_NORM` on the first accepted bit with a full window, or to `SQ_HOLD` if that window is all zeros.
- `SQ_NORM` to `SQ_HOLD` when an accepted bit finds three zeros in the window.
- `SQ_NORM` to `SQ_NORM` otherwise.
- `SQ_HOLD` to `SQ_VIOL` on the next accepted bit.
- `SQ_VIOL` to `SQ_NORM` on the next accepted bit.

A rail driver keeps two pieces of state: the polarity of the last mark, and the parity of ordinary marks sent since the last violation. From these it produces the pulses.

Top module: `b3zs_encoder`

## Requirements
- R1: Outside a substitution, a one is sent as a single pulse whose polarity is opposite to the previous pulse, and a zero is sent as no pulse on either rail.
- R2: Zero runs are split into groups of three, counted from the first zero of the run. Each complete group is replaced by a three-symbol pattern that ends in a violation. The middle symbol of the pattern is always no pulse. A shorter remainder of one or two zeros is sent as no pulse.
- R3: The first symbol of a substitution depends on the number of ordinary pulses since the last violation (counting from reset if there has been none). If that number is odd, the first symbol is no pulse (pattern 00V). If it is even, including zero, the first symbol is a pulse of alternating polarity (pattern B0V). As a result, an odd number of ordinary pulses lies between any two successive violations.
- R4: A violation pulse has the same polarity as the pulse before it. In B0V the violation therefore matches the inserted B pulse. The pulse count since the last violation restarts at zero after each violation.
- R5: `out_pos` and `out_neg` are never high in the same cycle. Both are low whenever `out_valid` is low.
- R6: The symbol for the k-th accepted bit is presented in the cycle after the (k+3)-th accepted bit. `out_valid` is high exactly in the cycle after an accepting clock once three bits are held. Cycles with `in_valid` low advance nothing and present `out_valid` low.
- R7: While and after synchronous reset, `out_valid`, `out_pos` and `out_neg` are low and the window is empty. The first pulse after reset is positive, and the pulse count starts even.
- R8: The line never carries three consecutive valid symbols without a pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Accept `in_bit` on this clock |
| in_bit | input | 1 | Unipolar data bit |
| out_valid | output | 1 | A line symbol is present on the rails |
| out_pos | output | 1 | Positive pulse |
| out_neg | output | 1 | Negative pulse |

## Verification
The pattern length is fixed at three, so the bench builds the block with its default window depth, which is the only legal value. It drives every 12-bit word after a fresh reset. This covers every zero-run length up to twelve, starting from both pulse parities and both last polarities. A second pass over every third word inserts idle cycles between accepted bits. That pass shows that latency is counted in accepted bits and not in clocks, and that idle cycles leave the rails quiet.

// File: rtl/b3zs_pkg.sv
package b3zs_pkg;

    // Number of zeros replaced by one substitution pattern.
    localparam int RUN_LEN = 3;

    // Phase of the substitution sequencer.
    typedef enum logic [1:0] {
        SQ_FILL = 2'd0,
        SQ_NORM = 2'd1,
        SQ_HOLD = 2'd2,
        SQ_VIOL = 2'd3
    } seq_state_e;

    // Kind of symbol to put on the line for the bit leaving the window.
    typedef enum logic [1:0] {
        SYM_ZERO = 2'd0,
        SYM_MARK = 2'd1,
        SYM_VIOL = 2'd2
    } sym_kind_e;

endpackage

// File: rtl/b3zs_window.sv
module b3zs_window #(
    parameter int DEPTH = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    input  logic             bit_in,
    output logic [DEPTH-1:0] win,
    output logic             full
);

    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

    logic [DEPTH-1:0] bits_q;
    logic [CNT_W-1:0] fill_q;

    // Oldest bit sits at index 0, newest enters at the top.
    always_ff @(posedge clk) begin
        if (rst) begin
            bits_q <= '0;
        end else if (step) begin
            bits_q <= {bit_in, bits_q[DEPTH-1:1]};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fill_q <= '0;
        end else if (step && (fill_q != CNT_FULL)) begin
            fill_q <= fill_q + 1'b1;
        end
    end

    assign win  = bits_q;
    assign full = (fill_q == CNT_FULL);

endmodule

// File: rtl/b3zs_seq.sv
module b3zs_seq
    import b3zs_pkg::*;
#(
    parameter int DEPTH = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    input  logic             full,
    input  logic [DEPTH-1:0] win,
    input  logic             parity_odd,
    output logic             sym_valid,
    output sym_kind_e        sym
);

    seq_state_e state_q;
    seq_state_e state_d;
    logic       run_zero;

    assign run_zero = (win == '0);

    // State register.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SQ_FILL;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state.
    always_comb begin
        state_d = state_q;
        if (step) begin
            unique case (state_q)
                SQ_FILL: begin
                    if (full) begin
                        state_d = run_zero ? SQ_HOLD : SQ_NORM;
                    end
                end
                SQ_NORM: state_d = run_zero ? SQ_HOLD : SQ_NORM;
                SQ_HOLD: state_d = SQ_VIOL;
                SQ_VIOL: state_d = SQ_NORM;
            endcase
        end
    end

    // Symbol for the bit leaving the window on this step.
    always_comb begin
        sym_valid = step && full;
        sym       = SYM_ZERO;
        unique case (state_q)
            SQ_FILL, SQ_NORM: begin
                if (run_zero) begin
                    sym = parity_odd ? SYM_ZERO : SYM_MARK;
                end else begin
                    sym = win[0] ? SYM_MARK : SYM_ZERO;
                end
            end
            SQ_HOLD: sym = SYM_ZERO;
            SQ_VIOL: sym = SYM_VIOL;
        endcase
    end

endmodule

// File: rtl/b3zs_rails.sv
module b3zs_rails
    import b3zs_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      step,
    input  logic      sym_valid,
    input  sym_kind_e sym,
    output logic      parity_odd,
    output logic      out_valid,
    output logic      out_pos,
    output logic      out_neg
);

    logic last_pos_q;   // 1: last pulse positive, 0: negative
    logic parity_q;     // ordinary pulses since last violation, mod 2
    logic pulse_pos;    // polarity of a pulse sent now

    always_comb begin
        unique case (sym)
            SYM_VIOL: pulse_pos = last_pos_q;
            default:  pulse_pos = ~last_pos_q;
        endcase
    end

    // Polarity and parity tracking.
    always_ff @(posedge clk) begin
        if (rst) begin
            last_pos_q <= 1'b0;
            parity_q   <= 1'b0;
        end else if (sym_valid) begin
            unique case (sym)
                SYM_MARK: begin
                    last_pos_q <= pulse_pos;
                    parity_q   <= ~parity_q;
                end
                SYM_VIOL: begin
                    last_pos_q <= pulse_pos;
                    parity_q   <= 1'b0;
                end
                default: begin
                    last_pos_q <= last_pos_q;
                    parity_q   <= parity_q;
                end
            endcase
        end
    end

    // Registered line outputs.
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_pos   <= 1'b0;
            out_neg   <= 1'b0;
        end else begin
            out_valid <= step && sym_valid;
            out_pos   <= sym_valid && (sym != SYM_ZERO) && pulse_pos;
            out_neg   <= sym_valid && (sym != SYM_ZERO) && !pulse_pos;
        end
    end

    assign parity_odd = parity_q;

endmodule

// File: rtl/b3zs_encoder.sv
module b3zs_encoder
    import b3zs_pkg::*;
#(
    parameter int DEPTH = RUN_LEN
) (
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    input  logic in_bit,
    output logic out_valid,
    output logic out_pos,
    output logic out_neg
);

    logic [DEPTH-1:0] win;
    logic             full;
    logic             parity_odd;
    logic             sym_valid;
    sym_kind_e        sym;

    b3zs_window #(.DEPTH(DEPTH)) u_window (
        .clk    (clk),
        .rst    (rst),
        .step   (in_valid),
        .bit_in (in_bit),
        .win    (win),
        .full   (full)
    );

    b3zs_seq #(.DEPTH(DEPTH)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .step       (in_valid),
        .full       (full),
        .win        (win),
        .parity_odd (parity_odd),
        .sym_valid  (sym_valid),
        .sym        (sym)
    );

    b3zs_rails u_rails (
        .clk        (clk),
        .rst        (rst),
        .step       (in_valid),
        .sym_valid  (sym_valid),
        .sym        (sym),
        .parity_odd (parity_odd),
        .out_valid  (out_valid),
        .out_pos    (out_pos),
        .out_neg    (out_neg)
    );

endmodule

// File: rtl/b3zs_encoder_chk.sv
module b3zs_encoder_chk (
    input logic clk,
    input logic rst,
    input logic in_valid,
    input logic out_valid,
    input logic out_pos,
    input logic out_neg
);

    logic       last_pos;
    logic       b_odd;
    logic       seen;
    logic [1:0] zrun;
    logic       pulse;
    logic       is_v;

    assign pulse = out_valid && (out_pos || out_neg);
    assign is_v  = pulse && (out_pos == last_pos);

    // Line state observed at the ports.
    always_ff @(posedge clk) begin
        if (rst) begin
            last_pos <= 1'b0;
            b_odd    <= 1'b0;
            seen     <= 1'b0;
            zrun     <= 2'd0;
        end else if (out_valid) begin
            if (pulse) begin
                last_pos <= out_pos;
                b_odd    <= is_v ? 1'b0 : ~b_odd;
                seen     <= 1'b1;
                zrun     <= 2'd0;
            end else if (zrun != 2'd3) begin
                zrun <= zrun + 2'd1;
            end
        end
    end

    p_rails_exclusive_r5: assert property (@(posedge clk) disable iff (rst)
        !(out_pos && out_neg));

    p_rails_idle_r5: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (!out_pos && !out_neg));

    p_valid_follows_input_r6: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid));

    p_odd_b_between_v_r3: assert property (@(posedge clk) disable iff (rst)
        is_v |-> b_odd);

    p_first_pulse_pos_r7: assert property (@(posedge clk) disable iff (rst)
        (pulse && !seen) |-> out_pos);

    p_zero_run_bound_r8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !pulse) |-> (zrun < 2'd2));

endmodule

bind b3zs_encoder b3zs_encoder_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .out_pos   (out_pos),
    .out_neg   (out_neg)
);

// File: tb/b3zs_encoder_bench.sv
module b3zs_encoder_bench;

    logic clk = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic in_bit = 1'b0;
    logic out_valid, out_pos, out_neg;

    int n_run = 0;
    int n_fail = 0;
    int cyc = 0;
    int exp_sym [0:19];
    string exp_tag [0:19];

    b3zs_encoder u_b3zs_encoder (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_bit    (in_bit),
        .out_valid (out_valid),
        .out_pos   (out_pos),
        .out_neg   (out_neg)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            n_fail++;
            $display("FAIL watchdog R6: run did not end, cycles %0d expected below 190000", cyc);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    task automatic check(string req, bit exp_v, int exp_s);
        bit ep, en;
        ep = exp_v && (exp_s > 0);
        en = exp_v && (exp_s < 0);
        n_run++;
        if (out_valid !== exp_v || out_pos !== ep || out_neg !== en) begin
            n_fail++;
            $display("FAIL %s: valid/pos/neg = %b%b%b expected %b%b%b",
                     req, out_valid, out_pos, out_neg, exp_v, ep, en);
        end
    endtask

    // Expected line symbols (+1, -1, 0) from R1-style rules: greedy groups
    // of three zeros, parity of pulses since last violation picks the head.
    function automatic void build_exp(int w, int n);
        int  last = -1;
        bit  par = 1'b0;
        int  i = 0;
        bit  b [0:21];
        for (int k = 0; k < 22; k++) b[k] = (k < n) ? w[k] : 1'b1;
        while (i < n) begin
            if (!b[i] && !b[i+1] && !b[i+2]) begin
                if (par) begin
                    exp_sym[i] = 0;            // 00V, R3
                end else begin
                    last = -last;              // B0V, R3
                    exp_sym[i] = last;
                end
                exp_tag[i]   = "R3";
                exp_sym[i+1] = 0;
                exp_tag[i+1] = "R2";
                exp_sym[i+2] = last;           // violation repeats, R4
                exp_tag[i+2] = "R4";
                par = 1'b0;
                i += 3;
            end else begin
                if (b[i]) begin
                    last = -last;
                    exp_sym[i] = last;
                    par = ~par;
                end else begin
                    exp_sym[i] = 0;
                end
                exp_tag[i] = "R1";
                i++;
            end
        end
    endfunction

    task automatic run_seq(int w, int n, bit gaps);
        int zr = 0;
        int zmax = 0;
        rst = 1'b1;
        in_valid = 1'b0;
        in_bit = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R7", 1'b0, 0);
        rst = 1'b0;
        build_exp(w, n);
        for (int i = 0; i < n; i++) begin
            if (gaps && ((w + i) % 3 == 0)) begin
                in_valid = 1'b0;
                @(posedge clk);
                @(negedge clk);
                check("R6", 1'b0, 0);
            end
            in_valid = 1'b1;
            in_bit = w[i];
            @(posedge clk);
            @(negedge clk);
            if (i >= 3) begin
                check(exp_tag[i-3], 1'b1, exp_sym[i-3]);
                if (!out_pos && !out_neg) zr++; else zr = 0;
                if (zr > zmax) zmax = zr;
            end else begin
                check("R6", 1'b0, 0);
            end
        end
        in_valid = 1'b0;
        n_run++;
        if (zmax > 2) begin
            n_fail++;
            $display("FAIL R8: longest pulse-free run %0d expected at most 2", zmax);
        end
    endtask

    initial begin
        // Full sweep of every 12-bit word, back to back (R1, R2, R3, R4, R7).
        for (int w = 0; w < 4096; w++) run_seq(w, 12, 1'b0);
        // Idle cycles between accepted bits (R5, R6).
        for (int w = 0; w < 4096; w += 3) run_seq(w, 12, 1'b1);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule